// File: doc/BRIEF.md
# Serial Flash Hold and Status-Write Lock Controller

This block is the front-end control of a serial flash slave. It samples the chip-select, serial clock, hold, write-protect and serial-data pins on a faster system clock and runs a small state machine that decides when the serial shifter may advance, when the serial output must float, and when the serial logic is held in reset. A pause request on the hold pin takes effect only while the serial clock sits in its low phase. A request made while the clock is high waits for the clock to fall, and a release works the same way. While paused, clock and data activity on the pins is ignored and the position inside the current byte is kept.

The block also owns the eight-bit status register. An opcode decoder pulses `wrsr_req` once a write-status command has been recognised. The block then collects the next eight data bits, most significant bit first. It commits them only if the write-protect pin is high or the lock bit (bit 7) of the status register is clear. Deasserting chip-select abandons any partial byte but keeps the stored status.

Hold state machine states: `ST_IDLE` (chip-select high or waiting for hold release), `ST_ACTIVE` (shifting), `ST_HOLD_PEND` (hold requested, clock still high), `ST_HOLD` (paused), `ST_REL_PEND` (release requested, clock still high). Transitions: any state goes to IDLE when chip-select is high. IDLE goes to ACTIVE when chip-select is low and hold is high. ACTIVE goes to HOLD on hold low with clock low, or to HOLD_PEND on hold low with clock high. HOLD_PEND goes to HOLD when the clock falls, or back to ACTIVE if hold returns high first. HOLD goes to ACTIVE on hold high with clock low, or to REL_PEND on hold high with clock high. REL_PEND goes to ACTIVE when the clock falls, or back to HOLD if hold drops again.

Top module: `spi_hold_lock_ctrl`

## Requirements
- R1: After system reset the status register reads 0x00, `shift_en` is 0, `so_hiz` is 1, `serial_rst` is 1 and `wrsr_commit` is 0.
- R2: While chip-select is high, `serial_rst` is 1, `shift_en` is 0 and `so_hiz` is 1. A partly received status byte is discarded and the stored status is kept.
- R3: With chip-select low, hold going low while the serial clock is low pauses shifting (`shift_en` 0) and floats the output (`so_hiz` 1).
- R4: Hold going low while the serial clock is high keeps the output driven (`so_hiz` 0) until the clock falls. The pause then begins.
- R5: Shifting never resumes while hold is low. A release with the clock low resumes shifting. A release with the clock high keeps the output floating until the clock falls.
- R6: Rising clock edges and data changes during a pause do not alter the bit position. The byte completes correctly after the pause.
- R7: After chip-select is raised during a pause, the block stays inactive while chip-select is low and hold is still low. It resumes only once hold is high.
- R8: After a `wrsr_req` pulse, the next eight rising clock edges in the active state deliver a byte, most significant bit first. If the write is allowed, the byte is stored and `wrsr_commit` is high for exactly one system clock cycle.
- R9: The write is allowed when write-protect is high, or when write-protect is low and status bit 7 is 0. When write-protect is low and bit 7 is 1, the status stays unchanged and no commit pulse appears.
- R10: Serial bits received without a preceding `wrsr_req` in the same selection do not change the status register. This includes a `wrsr_req` given while chip-select was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low system reset |
| cs_n | input | 1 | Chip-select pin, active low |
| sck | input | 1 | Serial clock pin |
| hold_n | input | 1 | Hold pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| si | input | 1 | Serial data in pin |
| wrsr_req | input | 1 | One-cycle pulse from the opcode decoder: status write recognised |
| shift_en | output | 1 | High while the serial shifter may advance |
| so_hiz | output | 1 | High when the serial output must be high-impedance |
| serial_rst | output | 1 | Internal reset for the serial logic |
| wrsr_commit | output | 1 | One-cycle strobe when a status byte is stored |
| status | output | 8 | Current status register, bit 7 is the lock bit |

## Verification
The gating rule is tried with a table of pin and lock-bit combinations. Each row first writes a starting status with write-protect high, then attempts a second write. This separates rows that must commit from rows that must leave the register alone, and it covers both setting and clearing the lock bit. Hold is exercised with the pin moving during the clock's low phase and during its high phase, for both entry and release. This shows whether the output floats at the right moment and whether bits clocked in during the pause disturb the final byte. A chip-select abort in mid-pause, data without a request, and a request made while deselected show that partial or unrequested bytes never reach the register.

// File: rtl/spi_hl_pkg.sv
package spi_hl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_HOLD_PEND,
        ST_HOLD,
        ST_REL_PEND
    } hold_state_t;

    // bit positions inside the synchronised pin vector
    localparam int PIN_W   = 5;
    localparam int IX_CS   = 0;
    localparam int IX_SCK  = 1;
    localparam int IX_HOLD = 2;
    localparam int IX_WP   = 3;
    localparam int IX_SI   = 4;
    // idle levels: cs high, sck low, hold high, wp high, si low
    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b01101;
endpackage

// File: rtl/shl_sync.sv
module shl_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/shl_hold_fsm.sv
module shl_hold_fsm
    import spi_hl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic shift_en,
    output logic so_hiz,
    output logic serial_rst
);
    hold_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (hold_n_s) state_d = ST_ACTIVE;
                ST_ACTIVE:    if (!hold_n_s) state_d = sck_s ? ST_HOLD_PEND : ST_HOLD;
                ST_HOLD_PEND: begin
                    if (hold_n_s)    state_d = ST_ACTIVE;
                    else if (!sck_s) state_d = ST_HOLD;
                end
                ST_HOLD:      if (hold_n_s) state_d = sck_s ? ST_REL_PEND : ST_ACTIVE;
                ST_REL_PEND:  begin
                    if (!hold_n_s)   state_d = ST_HOLD;
                    else if (!sck_s) state_d = ST_ACTIVE;
                end
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_en   = 1'b0;
        so_hiz     = 1'b1;
        serial_rst = 1'b0;
        unique case (state_q)
            ST_IDLE:      serial_rst = 1'b1;
            ST_ACTIVE:    begin shift_en = 1'b1; so_hiz = 1'b0; end
            ST_HOLD_PEND: so_hiz = 1'b0;
            ST_HOLD:      so_hiz = 1'b1;
            ST_REL_PEND:  so_hiz = 1'b1;
            default:      serial_rst = 1'b1;
        endcase
    end

    AST_IDLE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state_q == ST_IDLE)); // R2
    AST_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD && $past(state_q) != ST_REL_PEND)
        |-> !$past(sck_s)); // R3
    AST_NO_EXIT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !hold_n_s) |=> (state_q != ST_ACTIVE)); // R5
endmodule

// File: rtl/shl_wrsr.sv
module shl_wrsr #(
    parameter int DATA_W   = 8,
    parameter int LOCK_BIT = 7,
    localparam int CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_rst,
    input  logic              shift_en,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              wp_n_s,
    input  logic              wrsr_req,
    output logic              wrsr_commit,
    output logic [DATA_W-1:0] status
);
    logic              sck_prev;
    logic              armed;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] status_q;
    logic              commit_q;
    logic              sck_rise;
    logic              write_ok;
    logic [DATA_W-1:0] next_byte;

    assign sck_rise  = sck_s & ~sck_prev;
    assign write_ok  = wp_n_s | ~status_q[LOCK_BIT];
    assign next_byte = {shreg[DATA_W-2:0], si_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            status_q <= '0;
            commit_q <= 1'b0;
        end else if (serial_rst) begin
            armed    <= 1'b0;
            bit_cnt  <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (wrsr_req) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
            end else if (armed && shift_en && sck_rise) begin
                shreg <= next_byte;
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                    armed   <= 1'b0;
                    bit_cnt <= '0;
                    if (write_ok) begin
                        status_q <= next_byte;
                        commit_q <= 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign wrsr_commit = commit_q;
    assign status      = status_q;

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !serial_rst && !wrsr_req) |=> $stable(bit_cnt)); // R6
    AST_LOCK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != $past(status_q)) |-> ($past(wp_n_s) || !$past(status_q[LOCK_BIT]))); // R9
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q); // R8
    AST_NO_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        serial_rst |=> !commit_q); // R2
endmodule

// File: rtl/spi_hold_lock_ctrl.sv
module spi_hold_lock_ctrl
    import spi_hl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_W    = 8,
    parameter int LOCK_BIT    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                hold_n,
    input  logic                wp_n,
    input  logic                si,
    input  logic                wrsr_req,
    output logic                shift_en,
    output logic                so_hiz,
    output logic                serial_rst,
    output logic                wrsr_commit,
    output logic [STATUS_W-1:0] status
);
    logic [PIN_W-1:0] pins_raw, pins_s;

    always_comb begin
        pins_raw          = '0;
        pins_raw[IX_CS]   = cs_n;
        pins_raw[IX_SCK]  = sck;
        pins_raw[IX_HOLD] = hold_n;
        pins_raw[IX_WP]   = wp_n;
        pins_raw[IX_SI]   = si;
    end

    shl_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    shl_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s[IX_CS]),
        .sck_s      (pins_s[IX_SCK]),
        .hold_n_s   (pins_s[IX_HOLD]),
        .shift_en   (shift_en),
        .so_hiz     (so_hiz),
        .serial_rst (serial_rst)
    );

    shl_wrsr #(.DATA_W(STATUS_W), .LOCK_BIT(LOCK_BIT)) u_wrsr (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_rst  (serial_rst),
        .shift_en    (shift_en),
        .sck_s       (pins_s[IX_SCK]),
        .si_s        (pins_s[IX_SI]),
        .wp_n_s      (pins_s[IX_WP]),
        .wrsr_req    (wrsr_req),
        .wrsr_commit (wrsr_commit),
        .status      (status)
    );
endmodule

// File: tb/spi_hold_lock_ctrl_bench.sv
`timescale 1ns/1ps
module spi_hold_lock_ctrl_bench;
    localparam time PER = 5ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, wp_n = 1'b1, si = 1'b0, wrsr_req = 1'b0;
    logic shift_en, so_hiz, serial_rst, wrsr_commit;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    int commits = 0;

    always #(PER/2) clk = ~clk;

    spi_hold_lock_ctrl u_spi_hold_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .wp_n(wp_n), .si(si), .wrsr_req(wrsr_req), .shift_en(shift_en),
        .so_hiz(so_hiz), .serial_rst(serial_rst), .wrsr_commit(wrsr_commit),
        .status(status)
    );

    always @(posedge clk) if (rst_n && wrsr_commit) commits <= commits + 1;

    // {start, wp_n, data, expected status, expect commit}
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {8'h00, 1'b0, 8'h5C, 8'h5C, 1'b1},
        {8'h80, 1'b0, 8'h1C, 8'h80, 1'b0},
        {8'h80, 1'b1, 8'h1C, 8'h1C, 1'b1},
        {8'h9C, 1'b0, 8'h00, 8'h9C, 1'b0},
        {8'h3C, 1'b0, 8'hBC, 8'hBC, 1'b1},
        {8'h84, 1'b1, 8'h00, 8'h00, 1'b1}
    };

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bit_tx(input logic b);
        si = b;   settle();
        sck = 1;  settle();
        sck = 0;  settle();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_tx(v[i]);
    endtask

    task automatic pulse_req();
        @(negedge clk) wrsr_req = 1'b1;
        @(negedge clk) wrsr_req = 1'b0;
    endtask

    task automatic framed_write(input logic [7:0] v);
        cs_n = 0; settle();
        pulse_req();
        send_byte(v);
        cs_n = 1; settle();
    endtask

    initial begin
        #(PER * 150000);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check(status == 8'h00, "R1 status", status, 0);
        check(shift_en == 0 && so_hiz == 1, "R1 shift/hiz", {shift_en, so_hiz}, 1);
        check(serial_rst == 1 && wrsr_commit == 0, "R1 rst/commit", {serial_rst, wrsr_commit}, 2);
        rst_n = 1'b1;
        settle();

        // R9 R8 gating table
        for (int k = 0; k < NV; k++) begin
            wp_n = 1'b1;
            framed_write(VEC[k][25:18]);
            wp_n = VEC[k][17];
            settle();
            c0 = commits;
            framed_write(VEC[k][16:9]);
            check(status == VEC[k][8:1], "R9 status", status, VEC[k][8:1]);
            check((commits - c0) == int'(VEC[k][0]), "R8 commit count", commits - c0, VEC[k][0]);
        end
        wp_n = 1'b1;
        settle();

        // R2 deselected outputs
        check(serial_rst == 1 && shift_en == 0 && so_hiz == 1, "R2 deselected",
              {serial_rst, shift_en, so_hiz}, 5);

        // hold sequence, byte 0xA5
        c0 = commits;
        cs_n = 0; settle();
        check(shift_en == 1 && so_hiz == 0, "R5 active", {shift_en, so_hiz}, 2);
        pulse_req();
        bit_tx(1); bit_tx(0); bit_tx(1);
        hold_n = 0; settle();
        check(shift_en == 0 && so_hiz == 1, "R3 hold entry", {shift_en, so_hiz}, 1);
        bit_tx(1); bit_tx(1);
        hold_n = 1; settle();
        check(shift_en == 1 && so_hiz == 0, "R5 release sck low", {shift_en, so_hiz}, 2);
        si = 0; settle();
        sck = 1; settle();
        hold_n = 0; settle();
        check(so_hiz == 0, "R4 pending entry", so_hiz, 0);
        sck = 0; settle();
        check(so_hiz == 1 && shift_en == 0, "R4 entry on fall", {shift_en, so_hiz}, 1);
        si = 1; sck = 1; settle();
        hold_n = 1; settle();
        check(so_hiz == 1, "R5 deferred release", so_hiz, 1);
        sck = 0; settle();
        check(so_hiz == 0 && shift_en == 1, "R5 release on fall", {shift_en, so_hiz}, 2);
        bit_tx(0); bit_tx(1); bit_tx(0); bit_tx(1);
        check(status == 8'hA5, "R6 byte after pause", status, 8'hA5);
        check(commits - c0 == 1, "R6 commit", commits - c0, 1);
        cs_n = 1; settle();

        // R2 R7 abort during hold
        c0 = commits;
        cs_n = 0; settle();
        pulse_req();
        bit_tx(0); bit_tx(0); bit_tx(0); bit_tx(0);
        hold_n = 0; settle();
        cs_n = 1; settle();
        check(serial_rst == 1 && so_hiz == 1, "R2 abort", {serial_rst, so_hiz}, 3);
        cs_n = 0; settle();
        check(shift_en == 0 && so_hiz == 1, "R7 still held", {shift_en, so_hiz}, 1);
        hold_n = 1; settle();
        check(shift_en == 1, "R7 resume", shift_en, 1);
        bit_tx(0); bit_tx(0); bit_tx(0); bit_tx(0);
        check(status == 8'hA5 && commits == c0, "R2 partial dropped", status, 8'hA5);
        send_byte(8'h3C);
        check(status == 8'hA5 && commits == c0, "R10 no request", status, 8'hA5);
        cs_n = 1; settle();

        // R10 request while deselected
        pulse_req();
        cs_n = 0; settle();
        send_byte(8'h11);
        check(status == 8'hA5 && commits == c0, "R10 req while deselected", status, 8'hA5);
        cs_n = 1; settle();

        // R8 ordinary write and single-cycle strobe
        framed_write(8'h3C);
        check(status == 8'h3C, "R8 write", status, 8'h3C);
        check(commits - c0 == 1, "R8 one-cycle strobe", commits - c0, 1);
        check(status == 8'h3C, "R2 status kept deselected", status, 8'h3C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule